// File: doc/BRIEF.md
# Fiber Transmit Gate with Jabber Lockout

This block sits between a sampled attachment-unit transmit pair and the drive bit of a fiber LED. It decides when real frame data is present, passes that data to the LED, and fills the time between frames with a free-running square idle tone, nominally 1 MHz. A glitch filter keeps short noise pulses from opening the gate. A start-of-idle detector closes the gate only after the line has sat at its idle level long enough.

A jabber guard watches how long the gate stays open. If a transmission runs too long, the guard blocks data and raises a jabber flag for the collision logic, plus an active-low LED pin. The idle tone keeps going while the guard is locked. The lock is released only after an unbroken stretch of idle input. Any active sample during that stretch starts the count again. A strap turns the guard off.

All times are parameters counted in clock cycles. The defaults suit a 125 MHz clock: about 24 ns of glitch rejection, about 184 ns for start of idle, a 1.008 µs idle period, 20 ms before lockout and 0.5 s for release. Benches shrink the two long timers.

Top module: `fiber_tx_jabber`

## Requirements
- R1: After reset, `tx_active`=0, `jab_flag`=0, `jab_led_n`=1 and `led_drive`=1, since the idle tone starts in its high half.
- R2: A run of fewer than GLITCH_CYC consecutive edges with `do_neg`=1 leaves the gate shut. `tx_active` stays 0 and `led_drive` keeps the idle tone.
- R3: The gate opens on the edge at which `do_neg`=1 has been sampled on GLITCH_CYC consecutive edges. While the guard is clear, `tx_active` is 1 from that edge on.
- R4: An open gate shuts on the edge at which `do_neg`=0 has been sampled on IDLE_CYC consecutive edges. Shorter idle gaps inside a frame leave it open.
- R5: While `tx_active`=1, `led_drive` equals the `do_neg` value sampled at the previous edge. In this encoding, 1 means DO is negative and the LED is lit. 0 means DO is positive and the LED is dark.
- R6: Whenever `tx_active`=0, `led_drive` carries the idle tone. The tone is high for IDLE_HALF cycles, then low for IDLE_HALF cycles, and runs free from reset without regard to any frame.
- R7: When the gate has been open for JAB_CYC consecutive edges with the guard clear and the strap low, `jab_flag` rises. While `jab_flag`=1, `tx_active` is 0 and `led_drive` carries the idle tone.
- R8: A raised `jab_flag` clears on the edge at which `do_neg`=0 has been sampled on UNJAB_CYC consecutive edges. Any `do_neg`=1 sample restarts that count from zero.
- R9: `jab_led_n` is 0 exactly while `jab_flag` is 1.
- R10: While `jab_dis`=1, `jab_flag` is 0 from the next edge on, however long the gate stays open. Raising the strap while locked clears the lock at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| do_neg | input | 1 | Sampled DO level: 1 = pair negative (active), 0 = positive (idle) |
| jab_dis | input | 1 | Strap: 1 disables the jabber guard |
| led_drive | output | 1 | LED drive bit, 1 = lit |
| tx_active | output | 1 | Frame data is being sent to the LED |
| jab_flag | output | 1 | Jabber lockout active, for the collision logic |
| jab_led_n | output | 1 | Active-low jabber indicator |

## Verification
Short isolated active pulses of one and two cycles, set against a pulse of exactly the threshold width, show whether the glitch filter counts from the right place. Frames built from random runs, with internal idle gaps just below the start-of-idle length, separate a correct close from an early one. A closing gap of exactly the threshold length pins the edge on which the gate shuts.

One over-long frame, followed by a short active burst inside the release window, tells apart a release timer that restarts from one that only pauses. Long frames with the strap raised, and the strap raised during a lock, separate a disabled guard from a merely slow one. Seeded random frames and gaps of mixed length are compared edge by edge with a bench model, which covers the tone phase and the data pass-through.

// File: rtl/ftj_pkg.sv
package ftj_pkg;

  typedef enum logic {SQ_SHUT = 1'b0, SQ_OPEN = 1'b1} sq_state_e;
  typedef enum logic {JB_CLEAR = 1'b0, JB_LOCKED = 1'b1} jb_state_e;

  // Next value of a saturating run counter: zero when the run breaks.
  function automatic int unsigned run_step(input int unsigned cur,
                                           input logic match,
                                           input int unsigned lim);
    if (!match) return 0;
    if (cur >= lim) return lim;
    return cur + 1;
  endfunction

  // True on the edge that completes a run of lim matching samples.
  function automatic logic run_done(input int unsigned cur,
                                    input logic match,
                                    input int unsigned lim);
    return match && (cur + 1 >= lim);
  endfunction

  // Idle tone level for a phase in 0 .. 2*half-1.
  function automatic logic tone_level(input int unsigned phase,
                                      input int unsigned half);
    return phase < half;
  endfunction

  function automatic int unsigned phase_step(input int unsigned phase,
                                             input int unsigned half);
    return (phase + 1 >= 2 * half) ? 0 : phase + 1;
  endfunction

endpackage

// File: rtl/ftj_run_cnt.sv
module ftj_run_cnt #(
  parameter int unsigned LIMIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic match,
  output logic done
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= CW'(ftj_pkg::run_step(32'(cnt_q), match, LIMIT));
  end

  assign done = ftj_pkg::run_done(32'(cnt_q), match, LIMIT);
endmodule

// File: rtl/ftj_squelch.sv
module ftj_squelch #(
  parameter int unsigned GLITCH_CYC = 3,
  parameter int unsigned IDLE_CYC   = 23
) (
  input  logic clk,
  input  logic rst_n,
  input  logic do_neg,
  output logic sq_open,
  output logic unsq_evt,
  output logic soi_evt
);
  import ftj_pkg::*;

  logic [1:0] lvl_match;
  logic [1:0] run_hit;
  sq_state_e  st_q;

  assign lvl_match = {~do_neg, do_neg};

  // Index 0 watches the active level, index 1 the idle level.
  for (genvar g = 0; g < 2; g++) begin : g_run
    localparam int unsigned LIM = (g == 0) ? GLITCH_CYC : IDLE_CYC;
    ftj_run_cnt #(.LIMIT(LIM)) u_run (
      .clk  (clk),
      .rst_n(rst_n),
      .match(lvl_match[g]),
      .done (run_hit[g])
    );
  end

  assign unsq_evt = run_hit[0];
  assign soi_evt  = run_hit[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        st_q <= SQ_SHUT;
    else if (unsq_evt) st_q <= SQ_OPEN;
    else if (soi_evt)  st_q <= SQ_SHUT;
  end

  assign sq_open = (st_q == SQ_OPEN);
endmodule

// File: rtl/ftj_jabber.sv
module ftj_jabber #(
  parameter int unsigned JAB_CYC   = 2_500_000,
  parameter int unsigned UNJAB_CYC = 62_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sq_open,
  input  logic do_neg,
  input  logic jab_dis,
  output logic jab_flag,
  output logic jab_hit,
  output logic unjab_hit
);
  import ftj_pkg::*;

  jb_state_e st_q;
  logic      long_match;
  logic      quiet_match;

  assign long_match  = sq_open && (st_q == JB_CLEAR) && !jab_dis;
  assign quiet_match = (st_q == JB_LOCKED) && !do_neg;

  ftj_run_cnt #(.LIMIT(JAB_CYC)) u_long (
    .clk  (clk),
    .rst_n(rst_n),
    .match(long_match),
    .done (jab_hit)
  );

  ftj_run_cnt #(.LIMIT(UNJAB_CYC)) u_quiet (
    .clk  (clk),
    .rst_n(rst_n),
    .match(quiet_match),
    .done (unjab_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         st_q <= JB_CLEAR;
    else if (jab_dis)   st_q <= JB_CLEAR;
    else if (jab_hit)   st_q <= JB_LOCKED;
    else if (unjab_hit) st_q <= JB_CLEAR;
  end

  assign jab_flag = (st_q == JB_LOCKED);
endmodule

// File: rtl/ftj_idle_gen.sv
module ftj_idle_gen #(
  parameter int unsigned IDLE_HALF = 63
) (
  input  logic clk,
  input  logic rst_n,
  output logic idle_bit
);
  localparam int unsigned PW = $clog2(2 * IDLE_HALF);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= PW'(ftj_pkg::phase_step(32'(phase_q), IDLE_HALF));
  end

  assign idle_bit = ftj_pkg::tone_level(32'(phase_q), IDLE_HALF);
endmodule

// File: rtl/fiber_tx_jabber.sv
module fiber_tx_jabber #(
  parameter int unsigned GLITCH_CYC = 3,
  parameter int unsigned IDLE_CYC   = 23,
  parameter int unsigned IDLE_HALF  = 63,
  parameter int unsigned JAB_CYC    = 2_500_000,
  parameter int unsigned UNJAB_CYC  = 62_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic do_neg,
  input  logic jab_dis,
  output logic led_drive,
  output logic tx_active,
  output logic jab_flag,
  output logic jab_led_n
);
  logic sq_open;
  logic unsq_evt;
  logic soi_evt;
  logic jab_hit;
  logic unjab_hit;
  logic idle_bit;
  logic do_q;
  logic data_en;

  ftj_squelch #(.GLITCH_CYC(GLITCH_CYC), .IDLE_CYC(IDLE_CYC)) u_sq (
    .clk     (clk),
    .rst_n   (rst_n),
    .do_neg  (do_neg),
    .sq_open (sq_open),
    .unsq_evt(unsq_evt),
    .soi_evt (soi_evt)
  );

  ftj_jabber #(.JAB_CYC(JAB_CYC), .UNJAB_CYC(UNJAB_CYC)) u_jab (
    .clk      (clk),
    .rst_n    (rst_n),
    .sq_open  (sq_open),
    .do_neg   (do_neg),
    .jab_dis  (jab_dis),
    .jab_flag (jab_flag),
    .jab_hit  (jab_hit),
    .unjab_hit(unjab_hit)
  );

  ftj_idle_gen #(.IDLE_HALF(IDLE_HALF)) u_idle (
    .clk     (clk),
    .rst_n   (rst_n),
    .idle_bit(idle_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) do_q <= 1'b0;
    else        do_q <= do_neg;
  end

  assign data_en   = sq_open && !jab_flag;
  assign tx_active = data_en;
  assign led_drive = data_en ? do_q : idle_bit;
  assign jab_led_n = ~jab_flag;
endmodule

// File: rtl/ftj_chk.sv
module ftj_chk (
  input logic clk,
  input logic rst_n,
  input logic do_neg,
  input logic jab_dis,
  input logic sq_open,
  input logic unsq_evt,
  input logic soi_evt,
  input logic jab_flag,
  input logic jab_hit,
  input logic unjab_hit,
  input logic data_en,
  input logic led_drive
);
  // R3
  open_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sq_open) |-> $past(do_neg) && $past(unsq_evt));

  // R4
  open_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sq_open) |-> !$past(do_neg) && $past(soi_evt));

  // R5
  data_led_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_en |-> (led_drive == $past(do_neg)));

  // R7
  jab_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jab_flag) |-> $past(sq_open) && !$past(jab_dis));

  // R7
  jab_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jab_hit && !jab_dis |=> jab_flag);

  // R8
  jab_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(jab_flag) |-> $past(jab_dis) || !$past(do_neg));

  // R8
  unjab_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unjab_hit |=> !jab_flag);

  // R10
  strap_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jab_dis |=> !jab_flag);
endmodule

bind fiber_tx_jabber ftj_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .do_neg   (do_neg),
  .jab_dis  (jab_dis),
  .sq_open  (sq_open),
  .unsq_evt (unsq_evt),
  .soi_evt  (soi_evt),
  .jab_flag (jab_flag),
  .jab_hit  (jab_hit),
  .unjab_hit(unjab_hit),
  .data_en  (data_en),
  .led_drive(led_drive)
);

// File: tb/test_fiber_tx_jabber.sv
module test_fiber_tx_jabber;
  localparam int unsigned G = 3;
  localparam int unsigned I = 6;
  localparam int unsigned H = 5;
  localparam int unsigned J = 200;
  localparam int unsigned U = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic do_neg = 1'b0;
  logic jab_dis = 1'b0;
  logic led_drive, tx_active, jab_flag, jab_led_n;

  always #4 clk = ~clk;

  fiber_tx_jabber #(.GLITCH_CYC(G), .IDLE_CYC(I), .IDLE_HALF(H),
                    .JAB_CYC(J), .UNJAB_CYC(U)) i_fiber_tx_jabber (
    .clk(clk), .rst_n(rst_n), .do_neg(do_neg), .jab_dis(jab_dis),
    .led_drive(led_drive), .tx_active(tx_active),
    .jab_flag(jab_flag), .jab_led_n(jab_led_n)
  );

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  string tag = "R1";
  bit finished = 0;

  // Bench model built from the requirements.
  int unsigned act_len, quiet_len, open_len, rel_len, tone_ph;
  bit gate, locked, last_in;

  always @(posedge clk) begin
    if (!rst_n) begin
      act_len = 0; quiet_len = 0; open_len = 0; rel_len = 0; tone_ph = 0;
      gate = 0; locked = 0; last_in = 0;
    end else begin
      bit opens, closes, lock_now, free_now, was_counting_long;
      opens    = do_neg && (act_len + 1 >= G);
      closes   = !do_neg && (quiet_len + 1 >= I);
      was_counting_long = gate && !locked && !jab_dis;
      lock_now = was_counting_long && (open_len + 1 >= J);
      free_now = locked && !do_neg && (rel_len + 1 >= U);
      act_len   = do_neg ? ((act_len < G) ? act_len + 1 : G) : 0;
      quiet_len = !do_neg ? ((quiet_len < I) ? quiet_len + 1 : I) : 0;
      open_len  = was_counting_long ? ((open_len < J) ? open_len + 1 : J) : 0;
      rel_len   = (locked && !do_neg) ? ((rel_len < U) ? rel_len + 1 : U) : 0;
      if (opens) gate = 1; else if (closes) gate = 0;
      if (jab_dis) locked = 0; else if (lock_now) locked = 1; else if (free_now) locked = 0;
      tone_ph = (tone_ph == 2 * H - 1) ? 0 : tone_ph + 1;
      last_in = do_neg;
    end
  end

  function automatic logic want_tx();
    return gate && !locked;
  endfunction

  function automatic logic want_led();
    return want_tx() ? last_in : logic'(tone_ph < H);
  endfunction

  task automatic check(input string req, input string what, input logic got, input logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    check(tag, "tx_active", tx_active, want_tx());
    check(tag, "led_drive", led_drive, want_led());
    check(tag, "jab_flag", jab_flag, locked);
    check("R9", "jab_led_n", jab_led_n, ~locked);
  endtask

  task automatic step(input logic d);
    do_neg = d;
    @(negedge clk);
    compare_all();
  endtask

  task automatic gap(input int n);
    for (int k = 0; k < n; k++) step(1'b0);
  endtask

  // Frame: opens with G active samples, then random runs; idle runs stay below I.
  task automatic frame(input int n);
    int k;
    logic lv;
    for (int q = 0; q < int'(G); q++) step(1'b1);
    k = G;
    lv = 1'b0;
    while (k < n) begin
      int r;
      r = 1 + int'($urandom % 4);
      for (int q = 0; q < r && k < n; q++) begin
        step(lv);
        k++;
      end
      lv = ~lv;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R1 watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4662));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1", "tx_active", tx_active, 1'b0);
    check("R1", "jab_flag", jab_flag, 1'b0);
    check("R1", "jab_led_n", jab_led_n, 1'b1);
    check("R1", "led_drive", led_drive, 1'b1);

    tag = "R6";
    gap(25);

    tag = "R2";
    step(1'b1); gap(4);
    step(1'b1); step(1'b1); gap(4);
    check("R2", "tx_active", tx_active, 1'b0);

    tag = "R3";
    step(1'b1); step(1'b1);
    check("R3", "tx_active", tx_active, 1'b0);
    step(1'b1);
    check("R3", "tx_active", tx_active, 1'b1);

    tag = "R5";
    for (int k = 0; k < 30; k++) step(logic'($urandom % 2));
    step(1'b1);
    tag = "R4";
    gap(I - 1);
    check("R4", "tx_active", tx_active, 1'b1);
    step(1'b0);
    check("R4", "tx_active", tx_active, 1'b0);
    gap(10);

    tag = "R5";
    for (int f = 0; f < 24; f++) begin
      int len;
      len = 5 + int'($urandom % 180);
      if ($urandom % 6 == 0) len = int'(J) + 10 + int'($urandom % 40);
      frame(len);
      gap(1 + int'($urandom % 90));
    end
    gap(U + 5);

    tag = "R7";
    frame(int'(J) + 30);
    check("R7", "jab_flag", jab_flag, 1'b1);
    check("R9", "jab_led_n", jab_led_n, 1'b0);
    check("R7", "tx_active", tx_active, 1'b0);

    tag = "R8";
    gap(20);
    for (int k = 0; k < 4; k++) step(1'b1);
    gap(U - 1);
    check("R8", "jab_flag", jab_flag, 1'b1);
    step(1'b0);
    check("R8", "jab_flag", jab_flag, 1'b0);
    gap(10);

    tag = "R10";
    jab_dis = 1'b1;
    frame(int'(J) + 50);
    step(1'b1);
    check("R10", "jab_flag", jab_flag, 1'b0);
    check("R10", "tx_active", tx_active, 1'b1);
    gap(10);
    jab_dis = 1'b0;
    frame(int'(J) + 20);
    check("R10", "jab_flag", jab_flag, 1'b1);
    jab_dis = 1'b1;
    step(1'b0);
    check("R10", "jab_flag", jab_flag, 1'b0);
    jab_dis = 1'b0;
    gap(20);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule